// File: doc/BRIEF.md
# Prescaled Pulse-Width Modulator

This block drives a pulse-width-modulated waveform from a free-running counter. A prescaler divides the system clock into a slower count tick. The counter steps from zero up to a programmed period limit and then wraps. The primary output is active from count zero up to and including a programmed duty limit. The waveform therefore lasts `period_val + 1` ticks, of which `duty_val + 1` ticks are active.

Modulation runs only while both the enable bit and the clear-on-match bit are set. While it runs, a secondary output holds a programmed static level. Compare values written during a period are held back until that period ends, so no pulse is ever cut short or stretched. A duty value that is not below the period value counts as an illegal setting, and the primary output then stays active without a break.

Top module: `pwm_gen`

## Requirements
- R1: While modulation runs, the counter advances once every `prescale + 1` system clocks. The first advance comes at the `prescale + 1`-th rising edge after modulation starts.
- R2: The counter steps through 0, 1, … `period_val` and returns to 0 on the tick that follows, so each waveform lasts `period_val + 1` ticks.
- R3: The output is logically active while the count is less than or equal to `duty_val`, which gives `duty_val + 1` active ticks at the start of each period.
- R4: With `act_low` = 0 the active level of `pwm_out` is 1. With `act_low` = 1 the active level is 0 and every level of `pwm_out` is inverted.
- R5: `aux_out` equals `aux_level` while modulation runs and is 0 otherwise.
- R6: Modulation runs only when `pwm_en` = 1 and `clr_on_match` = 1. At all other times the counter is held at 0 and `pwm_out` sits at its inactive level, which is 1 when `act_low` = 1 and 0 otherwise.
- R7: If the applied `duty_val` is greater than or equal to the applied `period_val`, `pwm_out` stays at its active level for as long as modulation runs.
- R8: While modulation runs, a change to `period_val` or `duty_val` takes effect only at the start of the next period. While modulation is stopped, the block takes these values on every clock.
- R9: With `rst` = 1 at a rising edge, the prescaler, the counter and the applied compare values are all cleared to 0.
- R10: In the cycle in which modulation starts, the count is 0 and `pwm_out` is already at its active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| prescale | input | 8 | Count tick every `prescale + 1` clocks |
| pwm_en | input | 1 | Modulation enable |
| clr_on_match | input | 1 | Counter clears after reaching the period value; required for modulation |
| period_val | input | 16 | Period limit (period is value + 1 ticks) |
| duty_val | input | 16 | Duty limit (active time is value + 1 ticks) |
| act_low | input | 1 | 1 selects active-low polarity for `pwm_out` |
| aux_level | input | 1 | Static level for `aux_out` while modulating |
| pwm_out | output | 1 | Modulated output |
| aux_out | output | 1 | Secondary static output |

## Verification
The hardest case to reach is a compare value that changes in the middle of a running period. The old values must stay in force until the wrap, and the new ones must start exactly at the next count-zero. A directed sequence enables a five-tick period and rewrites both limits two ticks into it. The expected waveform then switches from the old formula to the new one at the predicted boundary clock. Random configurations with prescale, polarity and illegal duty settings mixed in confirm that every clock of two whole periods matches the expected waveform computed from tick index and period position.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    // Counter and prescaler widths shared by every unit of the block
    localparam int CNT_W = 16;
    localparam int DIV_W = 8;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [DIV_W-1:0] div_t;

    // Period and duty limits travel together
    typedef struct packed {
        cnt_t per;
        cnt_t duty;
    } cmp_t;

    typedef enum logic {
        POL_HIGH = 1'b0,
        POL_LOW  = 1'b1
    } pol_e;

    // Logical activity for a count position under a limit pair
    function automatic logic in_active(cnt_t c, cmp_t s);
        return (s.duty >= s.per) || (c <= s.duty);
    endfunction

    // Map logical activity onto a pin level
    function automatic logic drive_level(logic act, pol_e p);
        return (p == POL_LOW) ? ~act : act;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  div_t div_set,
    output logic tick
);

    div_t div_q;

    // A limit lowered below the running count still ends the interval
    assign tick = run && (div_q >= div_set);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    input  cnt_t per_lim,
    output cnt_t cnt,
    output logic at_end
);

    assign at_end = (cnt >= per_lim);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= at_end ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow
    import pwm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    input  logic at_end,
    input  cmp_t cmp_in,
    output cmp_t cmp_sh
);

    logic load;

    // Follow the inputs while idle; otherwise only at a wrap
    assign load = !run || (tick && at_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_sh <= '0;
        end else if (load) begin
            cmp_sh <= cmp_in;
        end
    end

endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] prescale,
    input  logic             pwm_en,
    input  logic             clr_on_match,
    input  logic [CNT_W-1:0] period_val,
    input  logic [CNT_W-1:0] duty_val,
    input  logic             act_low,
    input  logic             aux_level,
    output logic             pwm_out,
    output logic             aux_out
);

    logic mode_on;
    logic tick;
    logic at_end;
    cnt_t cnt_q;
    cmp_t cmp_in;
    cmp_t cmp_sh;
    pol_e pol;

    assign mode_on = pwm_en && clr_on_match;
    assign cmp_in  = '{per: period_val, duty: duty_val};
    assign pol     = pol_e'(act_low);

    pwm_prescaler u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (mode_on),
        .div_set (prescale),
        .tick    (tick)
    );

    pwm_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .run     (mode_on),
        .tick    (tick),
        .per_lim (cmp_sh.per),
        .cnt     (cnt_q),
        .at_end  (at_end)
    );

    pwm_shadow u_sh (
        .clk    (clk),
        .rst    (rst),
        .run    (mode_on),
        .tick   (tick),
        .at_end (at_end),
        .cmp_in (cmp_in),
        .cmp_sh (cmp_sh)
    );

    always_comb begin
        if (mode_on) begin
            pwm_out = drive_level(in_active(cnt_q, cmp_sh), pol);
            aux_out = aux_level;
        end else begin
            pwm_out = drive_level(1'b0, pol);
            aux_out = 1'b0;
        end
    end

endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk
    import pwm_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic mode_on,
    input logic tick,
    input cnt_t cnt_q,
    input logic at_end,
    input cnt_t per_sh,
    input cnt_t duty_sh,
    input logic aux_out,
    input logic act_low,
    input logic pwm_out
);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_on |=> cnt_q == '0);

    // R6
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_on |-> pwm_out == act_low);

    // R1
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_on && !tick) |=> $stable(cnt_q));

    // R2
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_on && tick && at_end) |=> cnt_q == '0);

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= per_sh);

    // R8
    limits_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_on && !(tick && at_end)) |=> ($stable(per_sh) && $stable(duty_sh)));

    // R5
    aux_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_on |-> !aux_out);

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (cnt_q == '0 && per_sh == '0 && duty_sh == '0));

endmodule

bind pwm_gen pwm_gen_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .mode_on (mode_on),
    .tick    (tick),
    .cnt_q   (cnt_q),
    .at_end  (at_end),
    .per_sh  (cmp_sh.per),
    .duty_sh (cmp_sh.duty),
    .aux_out (aux_out),
    .act_low (act_low),
    .pwm_out (pwm_out)
);

// File: tb/sim_pwm_gen.sv
`timescale 1ns/1ps
module sim_pwm_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  prescale;
    logic        pwm_en;
    logic        clr_on_match;
    logic [15:0] period_val;
    logic [15:0] duty_val;
    logic        act_low;
    logic        aux_level;
    logic        pwm_out;
    logic        aux_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwm_gen u0 (
        .clk          (clk),
        .rst          (rst),
        .prescale     (prescale),
        .pwm_en       (pwm_en),
        .clr_on_match (clr_on_match),
        .period_val   (period_val),
        .duty_val     (duty_val),
        .act_low      (act_low),
        .aux_level    (aux_level),
        .pwm_out      (pwm_out),
        .aux_out      (aux_out)
    );

    // Expected pin level k clocks after modulation starts
    function automatic logic exp_pwm(int k, int per, int dut, int pre, bit lowp);
        int  t;
        int  c;
        logic act;
        t   = k / (pre + 1);
        c   = t % (per + 1);
        act = (dut >= per) || (c <= dut);
        return lowp ? ~act : act;
    endfunction

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Program values while idle, then start and compare every clock
    task automatic run_cfg(string req, int per, int dut, int pre, bit lowp, bit aux, int n);
        @(negedge clk);
        pwm_en = 1'b0; clr_on_match = 1'b1;
        period_val = 16'(per); duty_val = 16'(dut);
        prescale = 8'(pre); act_low = lowp; aux_level = aux;
        @(negedge clk);
        pwm_en = 1'b1;
        for (int k = 0; k < n; k++) begin
            #1;
            check(req, pwm_out, exp_pwm(k, per, dut, pre, lowp));
            check("R5", aux_out, aux);
            @(negedge clk);
        end
        pwm_en = 1'b0;
        #1;
        check("R6 idle after stop", pwm_out, lowp);
        check("R5 idle aux", aux_out, 1'b0);
    endtask

    initial begin
        #(20000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; prescale = '0; pwm_en = 1'b0; clr_on_match = 1'b0;
        period_val = '0; duty_val = '0; act_low = 1'b0; aux_level = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        // R9: reset state, outputs idle
        check("R9 reset pwm", pwm_out, 1'b0);
        check("R9 reset aux", aux_out, 1'b0);
        rst = 1'b0;

        // R6: enable without clear-on-match does nothing
        @(negedge clk);
        pwm_en = 1'b1; clr_on_match = 1'b0; act_low = 1'b1;
        period_val = 16'd3; duty_val = 16'd1;
        for (int i = 0; i < 6; i++) begin
            #1;
            check("R6 clr off", pwm_out, 1'b1);
            check("R6 clr off aux", aux_out, 1'b0);
            @(negedge clk);
        end

        // R2 R3 R10: basic waveform, prescale 0
        run_cfg("R2 R3 R10 basic", 4, 1, 0, 1'b0, 1'b1, 15);
        // R1: prescaled ticks
        run_cfg("R1 prescale", 3, 0, 2, 1'b0, 1'b0, 30);
        // R4: inverted polarity
        run_cfg("R4 polarity", 5, 2, 1, 1'b1, 1'b1, 26);
        // R7: duty equal and above period
        run_cfg("R7 duty equal", 3, 3, 0, 1'b0, 1'b0, 10);
        run_cfg("R7 duty above", 2, 9, 1, 1'b1, 1'b1, 10);
        // R2: smallest legal period
        run_cfg("R2 min period", 1, 0, 0, 1'b0, 1'b1, 8);

        // R8: change limits two ticks into a five-tick period
        @(negedge clk);
        pwm_en = 1'b0; clr_on_match = 1'b1; prescale = '0; act_low = 1'b0;
        period_val = 16'd4; duty_val = 16'd1;
        @(negedge clk);
        pwm_en = 1'b1;
        for (int k = 0; k < 14; k++) begin
            if (k == 2) begin
                period_val = 16'd2; duty_val = 16'd0;
            end
            #1;
            if (k < 5) check("R8 old limits", pwm_out, exp_pwm(k, 4, 1, 0, 1'b0));
            else       check("R8 new limits", pwm_out, exp_pwm(k - 5, 2, 0, 0, 1'b0));
            @(negedge clk);
        end
        pwm_en = 1'b0;

        // Random configurations
        for (int r = 0; r < 24; r++) begin
            int per, dut, pre;
            bit lowp, aux;
            per  = int'($urandom_range(15, 1));
            dut  = int'($urandom_range(per + 2, 0));
            pre  = int'($urandom_range(3, 0));
            lowp = 1'($urandom_range(1, 0));
            aux  = 1'($urandom_range(1, 0));
            run_cfg("R1 R2 R3 R4 R7 random", per, dut, pre, lowp, aux,
                    (per + 1) * (pre + 1) * 2 + 3);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule